// File: doc/BRIEF.md
# Multiplexed Byte-Bus Flash Front End

This block is the device-side front end of a flash-style memory whose command, address and data bytes all travel over one shared 8-bit port. The host marks each write cycle as a command or an address with two latch strobes. When neither strobe is high, the byte is payload data. The active-low chip, write and read enables are asynchronous to the block. They pass through two-flop synchronisers on a fast system clock, and their edges are found by comparison with the previous synchronised value. For this reason the system clock must run at least four times faster than the strobe toggle rate.

Written bytes go to a command register, to a column/row address register (one column byte, then the row bytes, least significant first) or, after a program setup command, to a data-in stream tagged with a self-incrementing column. On reads, each falling read-enable edge places the page-buffer byte at the current column on the port and steps the column. Array work is modelled by a busy timer. The timer is loaded from one of three duration inputs, one each for read transfer, program and erase. While the timer runs, the block pulls its open-drain ready/busy line low. Raising chip enable after a read, while the block is ready, enters standby. While the block is busy, chip enable and write cycles are ignored.

Top module: `nand_bus_frontend`

## Requirements
- R1: A write-enable rising edge with chip enable low, command strobe high and the block ready loads `io_in` into `cmd_q` (reset value 0xFF). The command strobe wins if both strobes are high.
- R2: A write with address strobe high (command strobe low) stores address bytes in order: byte 0 into `col_addr`, byte 1 into `row_addr[7:0]`, byte 2 into `row_addr[15:8]`. Further address bytes are ignored.
- R3: Every accepted command clears the address byte counter, so the next address byte is taken as a column byte again.
- R4: After command 0x00 (read), the third address byte starts a read transfer. `rb_pull_low` (1 = line pulled low, 0 = released) is then high for exactly `t_read` clock cycles.
- R5: Each falling read-enable edge while chip enable is low and the block is ready drives `io_out` with the page-buffer byte at the current column and advances the column by one. The read column starts at the column address byte.
- R6: `io_oe` is high only while synchronised chip enable is low, synchronised read enable is low and `rb_pull_low` is 0.
- R7: A rising chip-enable edge while ready and after a read command sets `standby`. A falling chip-enable edge clears it.
- R8: While `rb_pull_low` is high, chip-enable edges do not set `standby`, write cycles are ignored, and the busy period runs to its full length.
- R9: After command 0x80 (program setup), each data write pulses `din_valid` for one cycle with `din_byte` and `din_col`, and the column steps by one. Command 0x10 then pulls busy low for `t_prog` cycles.
- R10: Data writes made when the last command was not 0x80 produce no `din_valid` pulse.
- R11: Command 0x60 followed by command 0xD0 pulls busy low for `t_erase` cycles.
- R12: While `wp_n` is low, commands 0x10 and 0xD0 start no busy period.
- R13: Reset leaves `rb_pull_low`, `io_oe` and `standby` at 0 and `cmd_q` at 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| ce_n | input | 1 | chip enable, active low, asynchronous |
| we_n | input | 1 | write enable, active low, asynchronous |
| re_n | input | 1 | read enable, active low, asynchronous |
| cle | input | 1 | command latch strobe |
| ale | input | 1 | address latch strobe |
| wp_n | input | 1 | write protect, active low |
| io_in | input | 8 | shared byte port, inbound |
| io_out | output | 8 | shared byte port, outbound |
| io_oe | output | 1 | port output enable |
| rb_pull_low | output | 1 | open-drain ready/busy pull-down enable |
| standby | output | 1 | low-power standby flag |
| t_read | input | 16 | read transfer busy length in cycles |
| t_prog | input | 16 | program busy length in cycles |
| t_erase | input | 16 | erase busy length in cycles |
| cmd_q | output | 8 | command register |
| col_addr | output | 8 | column address register |
| row_addr | output | 16 | row address register |
| pb_addr | output | 8 | page buffer read column |
| pb_rdata | input | 8 | page buffer byte at `pb_addr` |
| din_valid | output | 1 | data-in byte strobe |
| din_byte | output | 8 | data-in byte |
| din_col | output | 8 | column of the data-in byte |

## Verification
The assertions assume that the host respects the strobe protocol. Each strobe level is held for at least four system clocks. `io_in`, `cle` and `ale` are stable for the whole write-enable low phase. A write-enable edge never coincides with a chip-enable edge, so a standby flag is always cleared before a write can start a busy period. The bench drives every strobe from tasks that hold each level for four clocks and change only one edge-sensitive strobe at a time. The data and latch inputs settle together with the falling write enable.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

    localparam int IO_W = 8;

    localparam logic [IO_W-1:0] OP_READ        = 8'h00;
    localparam logic [IO_W-1:0] OP_PROG_SETUP  = 8'h80;
    localparam logic [IO_W-1:0] OP_PROG_GO     = 8'h10;
    localparam logic [IO_W-1:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [IO_W-1:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [IO_W-1:0] CMD_RST_VAL    = 8'hFF;

    typedef enum logic [1:0] {MD_IDLE, MD_READ, MD_PROG, MD_ERASE} mode_t;
    typedef enum logic [1:0] {BK_READ, BK_PROG, BK_ERASE} busy_kind_t;

    typedef struct packed {
        logic            ce_n;
        logic            we_n;
        logic            re_n;
        logic            cle;
        logic            ale;
        logic            wp_n;
        logic [IO_W-1:0] io;
    } pins_t;

    localparam pins_t PINS_IDLE = '{ce_n: 1'b1, we_n: 1'b1, re_n: 1'b1,
                                    cle: 1'b0, ale: 1'b0, wp_n: 1'b1,
                                    io: '0};

    // Mode entered after a command byte; confirm opcodes return to idle.
    function automatic mode_t mode_after(input logic [IO_W-1:0] op);
        case (op)
            OP_READ:        return MD_READ;
            OP_PROG_SETUP:  return MD_PROG;
            OP_ERASE_SETUP: return MD_ERASE;
            default:        return MD_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/nbf_sync.sv
module nbf_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        logic stable;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta   <= RST_VAL[i];
                stable <= RST_VAL[i];
            end else begin
                meta   <= d[i];
                stable <= meta;
            end
        end
        assign q[i] = stable;
    end

endmodule

// File: rtl/nbf_busy_timer.sv
module nbf_busy_timer
    import nbf_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  busy_kind_t    kind,
    input  logic [TW-1:0] t_read,
    input  logic [TW-1:0] t_prog,
    input  logic [TW-1:0] t_erase,
    output logic          busy
);

    logic [TW-1:0] cnt;
    logic [TW-1:0] load_val;

    always_comb begin
        case (kind)
            BK_PROG:  load_val = t_prog;
            BK_ERASE: load_val = t_erase;
            default:  load_val = t_read;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R4
    busy_load_chk: assert property (@(posedge clk) disable iff (rst)
        (start && load_val != '0) |=> busy);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != 1 && !start) |=> busy);

endmodule

// File: rtl/nbf_decode.sv
module nbf_decode
    import nbf_pkg::*;
#(
    parameter int CW = 8,
    parameter int RW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_ev,
    input  logic            re_step,
    input  logic            cle,
    input  logic            ale,
    input  logic            wp_ok,
    input  logic            busy,
    input  logic [IO_W-1:0] io,
    output logic [IO_W-1:0] cmd_q,
    output mode_t           mode,
    output logic [CW-1:0]   col_addr,
    output logic [RW-1:0]   row_addr,
    output logic [CW-1:0]   col_ptr,
    output logic            start,
    output busy_kind_t      start_kind,
    output logic            din_valid,
    output logic [IO_W-1:0] din_byte,
    output logic [CW-1:0]   din_col
);

    localparam int ROW_BYTES  = RW / IO_W;
    localparam int ADDR_BYTES = 1 + ROW_BYTES;
    localparam int IW         = $clog2(ADDR_BYTES + 1);

    logic [IW-1:0] addr_idx;
    logic          is_cmd, is_addr, is_data;

    assign is_cmd  = wr_ev && cle;
    assign is_addr = wr_ev && !cle && ale;
    assign is_data = wr_ev && !cle && !ale && (mode == MD_PROG);

    always_comb begin
        start      = 1'b0;
        start_kind = BK_READ;
        if (is_cmd) begin
            if (io == OP_PROG_GO && mode == MD_PROG && wp_ok) begin
                start      = 1'b1;
                start_kind = BK_PROG;
            end else if (io == OP_ERASE_GO && mode == MD_ERASE && wp_ok) begin
                start      = 1'b1;
                start_kind = BK_ERASE;
            end
        end else if (is_addr && addr_idx == IW'(ADDR_BYTES - 1) && mode == MD_READ) begin
            start = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= CMD_RST_VAL;
            mode      <= MD_IDLE;
            addr_idx  <= '0;
            col_addr  <= '0;
            row_addr  <= '0;
            col_ptr   <= '0;
            din_valid <= 1'b0;
            din_byte  <= '0;
            din_col   <= '0;
        end else begin
            din_valid <= 1'b0;
            if (is_cmd) begin
                cmd_q    <= io;
                mode     <= mode_after(io);
                addr_idx <= '0;
            end else if (is_addr) begin
                if (addr_idx < IW'(ADDR_BYTES)) begin
                    if (addr_idx == '0) begin
                        col_addr <= CW'(io);
                        col_ptr  <= CW'(io);
                    end else begin
                        row_addr[(int'(addr_idx) - 1) * IO_W +: IO_W] <= io;
                    end
                    addr_idx <= addr_idx + 1'b1;
                end
            end else if (is_data) begin
                din_valid <= 1'b1;
                din_byte  <= io;
                din_col   <= col_ptr;
                col_ptr   <= col_ptr + 1'b1;
            end else if (re_step) begin
                col_ptr <= col_ptr + 1'b1;
            end
        end
    end

    // R8
    no_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R12
    wp_block_chk: assert property (@(posedge clk) disable iff (rst)
        (start && start_kind != BK_READ) |-> wp_ok);

    // R3
    addr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        is_cmd |=> addr_idx == '0);

    // R5
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (re_step && !wr_ev) |=> col_ptr == $past(col_ptr) + 1'b1);

endmodule

// File: rtl/nand_bus_frontend.sv
module nand_bus_frontend
    import nbf_pkg::*;
#(
    parameter int CW = 8,
    parameter int RW = 16,
    parameter int TW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ce_n,
    input  logic            we_n,
    input  logic            re_n,
    input  logic            cle,
    input  logic            ale,
    input  logic            wp_n,
    input  logic [IO_W-1:0] io_in,
    output logic [IO_W-1:0] io_out,
    output logic            io_oe,
    output logic            rb_pull_low,
    output logic            standby,
    input  logic [TW-1:0]   t_read,
    input  logic [TW-1:0]   t_prog,
    input  logic [TW-1:0]   t_erase,
    output logic [IO_W-1:0] cmd_q,
    output logic [CW-1:0]   col_addr,
    output logic [RW-1:0]   row_addr,
    output logic [CW-1:0]   pb_addr,
    input  logic [IO_W-1:0] pb_rdata,
    output logic            din_valid,
    output logic [IO_W-1:0] din_byte,
    output logic [CW-1:0]   din_col
);

    localparam int PW = $bits(pins_t);

    pins_t         raw, s;
    logic [PW-1:0] s_vec;
    logic          ce_p, we_p, re_p;
    logic          we_rise, re_fall, ce_rise, ce_fall;
    logic          wr_ev, re_step, busy, start;
    busy_kind_t    start_kind;
    mode_t         mode;
    logic [CW-1:0] col_ptr;

    assign raw = '{ce_n: ce_n, we_n: we_n, re_n: re_n, cle: cle,
                   ale: ale, wp_n: wp_n, io: io_in};

    nbf_sync #(.W(PW), .RST_VAL(PINS_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (s_vec)
    );
    assign s = pins_t'(s_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_p <= 1'b1;
            we_p <= 1'b1;
            re_p <= 1'b1;
        end else begin
            ce_p <= s.ce_n;
            we_p <= s.we_n;
            re_p <= s.re_n;
        end
    end

    assign we_rise = s.we_n && !we_p;
    assign re_fall = !s.re_n && re_p;
    assign ce_rise = s.ce_n && !ce_p;
    assign ce_fall = !s.ce_n && ce_p;
    assign wr_ev   = we_rise && !s.ce_n && !busy;
    assign re_step = re_fall && !s.ce_n && !busy;

    nbf_decode #(.CW(CW), .RW(RW)) u_decode (
        .clk        (clk),
        .rst        (rst),
        .wr_ev      (wr_ev),
        .re_step    (re_step),
        .cle        (s.cle),
        .ale        (s.ale),
        .wp_ok      (s.wp_n),
        .busy       (busy),
        .io         (s.io),
        .cmd_q      (cmd_q),
        .mode       (mode),
        .col_addr   (col_addr),
        .row_addr   (row_addr),
        .col_ptr    (col_ptr),
        .start      (start),
        .start_kind (start_kind),
        .din_valid  (din_valid),
        .din_byte   (din_byte),
        .din_col    (din_col)
    );

    nbf_busy_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .kind    (start_kind),
        .t_read  (t_read),
        .t_prog  (t_prog),
        .t_erase (t_erase),
        .busy    (busy)
    );

    assign pb_addr     = col_ptr;
    assign rb_pull_low = busy;
    assign io_oe       = !s.ce_n && !s.re_n && !busy;

    always_ff @(posedge clk) begin
        if (rst)
            io_out <= '0;
        else if (re_step)
            io_out <= pb_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            standby <= 1'b0;
        else if (ce_rise && !busy && mode == MD_READ)
            standby <= 1'b1;
        else if (ce_fall)
            standby <= 1'b0;
    end

    // R6
    oe_ready_chk: assert property (@(posedge clk) disable iff (rst)
        io_oe |-> !rb_pull_low);

    // R7
    standby_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(standby) |-> !rb_pull_low);

endmodule

// File: tb/test_nand_bus_frontend.sv
`timescale 1ns/1ps
module test_nand_bus_frontend;

    logic        clk = 1'b0;
    logic        rst;
    logic        ce_n, we_n, re_n, cle, ale, wp_n;
    logic [7:0]  io_in, io_out, cmd_q, col_addr, pb_addr, pb_rdata;
    logic [7:0]  din_byte, din_col;
    logic [15:0] row_addr, t_read, t_prog, t_erase;
    logic        io_oe, rb_pull_low, standby, din_valid;

    logic [7:0]  page [256];
    int          total = 0, bad = 0;
    int          busy_total = 0;
    int          oe_mismatch = 0, oe_samples = 0;
    logic [1:0]  h1 = 2'b11, h2 = 2'b11;
    logic [15:0] din_q [$];
    bit          done = 0;

    always #5 clk = ~clk;

    assign pb_rdata = page[pb_addr];

    nand_bus_frontend i_nand_bus_frontend (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .re_n(re_n),
        .cle(cle), .ale(ale), .wp_n(wp_n), .io_in(io_in), .io_out(io_out),
        .io_oe(io_oe), .rb_pull_low(rb_pull_low), .standby(standby),
        .t_read(t_read), .t_prog(t_prog), .t_erase(t_erase),
        .cmd_q(cmd_q), .col_addr(col_addr), .row_addr(row_addr),
        .pb_addr(pb_addr), .pb_rdata(pb_rdata), .din_valid(din_valid),
        .din_byte(din_byte), .din_col(din_col)
    );

    // Behavioural reference for the output enable, compared every clock.
    always @(posedge clk) begin
        h2 <= h1;
        h1 <= {ce_n, re_n};
    end

    always @(negedge clk) begin
        if (!rst) begin
            logic exp_oe;
            exp_oe = (h2 == 2'b00) && !rb_pull_low;
            oe_samples++;
            if (io_oe !== exp_oe) oe_mismatch++;
            if (rb_pull_low) busy_total++;
            if (din_valid) din_q.push_back({din_col, din_byte});
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic a, input logic [7:0] b);
        @(negedge clk);
        cle = c; ale = a; io_in = b; we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic read_byte(input logic [7:0] exp, input string req);
        @(negedge clk);
        re_n = 1'b0;
        repeat (4) @(negedge clk);
        check(req, {24'd0, io_out}, {24'd0, exp});
        check("R6 oe while reading", {31'd0, io_oe}, 32'd1);
        re_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R6 oe after read", {31'd0, io_oe}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) page[i] = 8'(i * 7 + 3);
        rst = 1'b1; ce_n = 1'b1; we_n = 1'b1; re_n = 1'b1;
        cle = 1'b0; ale = 1'b0; wp_n = 1'b1; io_in = 8'h00;
        t_read = 16'd20; t_prog = 16'd30; t_erase = 16'd40;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R13 rb", {31'd0, rb_pull_low}, 32'd0);
        check("R13 oe", {31'd0, io_oe}, 32'd0);
        check("R13 standby", {31'd0, standby}, 32'd0);
        check("R13 cmd", {24'd0, cmd_q}, 32'hFF);

        ce_n = 1'b0;
        repeat (4) @(negedge clk);

        wr(1, 0, 8'h60);
        check("R1 cmd latch", {24'd0, cmd_q}, 32'h60);
        wr(1, 1, 8'h70);
        check("R1 cle priority", {24'd0, cmd_q}, 32'h70);
        check("R1 cle priority col", {24'd0, col_addr}, 32'h00);

        wr(0, 0, 8'hAB);
        check("R10 no din outside program", din_q.size(), 0);

        begin
            int b0;
            wr(1, 0, 8'h00);
            wr(0, 1, 8'h07);
            wr(1, 0, 8'h00);
            b0 = busy_total;
            wr(0, 1, 8'h05);
            wr(0, 1, 8'h34);
            wr(0, 1, 8'h12);
            repeat (30) @(negedge clk);
            check("R3 counter cleared col", {24'd0, col_addr}, 32'h05);
            check("R2 row bytes", {16'd0, row_addr}, 32'h1234);
            check("R4 read busy length", busy_total - b0, 20);
            wr(0, 1, 8'h99);
            check("R2 extra addr ignored", {24'd0, col_addr}, 32'h05);
        end

        read_byte(page[5], "R5 first byte");
        read_byte(page[6], "R5 second byte");
        read_byte(page[7], "R5 third byte");

        @(negedge clk); ce_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 standby set", {31'd0, standby}, 32'd1);
        ce_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 standby cleared", {31'd0, standby}, 32'd0);

        begin
            int b0;
            t_read = 16'd80;
            wr(1, 0, 8'h00);
            wr(0, 1, 8'h10);
            wr(0, 1, 8'h00);
            b0 = busy_total;
            wr(0, 1, 8'h00);
            ce_n = 1'b1;
            repeat (4) @(negedge clk);
            check("R8 busy during ce high", {31'd0, rb_pull_low}, 32'd1);
            check("R8 no standby while busy", {31'd0, standby}, 32'd0);
            ce_n = 1'b0;
            repeat (4) @(negedge clk);
            wr(1, 0, 8'h60);
            check("R8 write ignored while busy", {24'd0, cmd_q}, 32'h00);
            repeat (80) @(negedge clk);
            check("R8 full busy length", busy_total - b0, 80);
            check("R8 standby stays clear", {31'd0, standby}, 32'd0);
        end

        begin
            int b0;
            logic [15:0] e;
            wr(1, 0, 8'h80);
            wr(0, 1, 8'h20);
            wr(0, 1, 8'h00);
            wr(0, 1, 8'h00);
            wr(0, 0, 8'hAA);
            wr(0, 0, 8'h55);
            check("R9 din count", din_q.size(), 2);
            e = (din_q.size() > 0) ? din_q.pop_front() : 16'hxxxx;
            check("R9 din first", {16'd0, e}, 32'h20AA);
            e = (din_q.size() > 0) ? din_q.pop_front() : 16'hxxxx;
            check("R9 din second", {16'd0, e}, 32'h2155);
            b0 = busy_total;
            wr(1, 0, 8'h10);
            repeat (40) @(negedge clk);
            check("R9 program busy length", busy_total - b0, 30);

            b0 = busy_total;
            wr(1, 0, 8'h60);
            wr(1, 0, 8'hD0);
            repeat (50) @(negedge clk);
            check("R11 erase busy length", busy_total - b0, 40);

            wp_n = 1'b0;
            repeat (4) @(negedge clk);
            b0 = busy_total;
            wr(1, 0, 8'h80);
            wr(1, 0, 8'h10);
            wr(1, 0, 8'h60);
            wr(1, 0, 8'hD0);
            repeat (50) @(negedge clk);
            check("R12 protected no busy", busy_total - b0, 0);
            wp_n = 1'b1;
        end

        total++;
        if (oe_mismatch != 0 || oe_samples == 0) begin
            bad++;
            $display("FAIL R6 per-clock oe model actual=%0d mismatches expected=0", oe_mismatch);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule